// File: doc/BRIEF.md
# Two-Channel Target-Time and Periodic Output Generator

This block turns a running time-of-day value into output waveforms on a small set of general-purpose pins. It holds two independent channels. Each channel is programmed with a start time, a period, an on/off flag and a pin number, all in a single write cycle. The block picks the mode from the period. In target-time mode, a comparator watches the time value. When the time reaches the programmed target, the channel toggles its output and moves the target forward by one period. In frequency mode, the channel makes a free-running square wave. Its edges are placed every half period, starting at the start time.

Time values are 64 bits wide. Whole seconds sit in the upper 32 bits and nanoseconds in the lower 32 bits, and the nanoseconds field stays below 10^9. The time-of-day counter lives outside the block and drives `tod_sec`/`tod_ns`. The block can step that time by any amount from one cycle to the next.

A pin router maps each channel onto one of four pins. The same router tracks two input-capture selections and keeps any pin from acting as an input and an output at once. An interrupt unit collects one sticky status bit per channel for target hits, plus one for every change of the seconds value. It raises a single masked request line from them.

Top module: `tgt_pulse_gen`

## Requirements
- R1: While reset is held and right after it, no pin is driven (`pin_oe`=0, `pin_out`=0), both capture enables are 0, all status bits are 0 and `irq` is 0.
- R2: A write selects frequency mode when the period seconds field is 0 and the nanoseconds field is at most 70,000,000 or exactly 125,000,000, 250,000,000 or 500,000,000. Any other period selects target-time mode, including 70,000,001 ns and any period with nonzero seconds.
- R3: In target-time mode, on the first clock edge where {`tod_sec`,`tod_ns`} is at least the target, the channel output toggles and the target advances by the period. When the nanoseconds sum reaches 10^9, the carry goes into seconds. The first target is the start time.
- R4: In frequency mode, the output toggles first at the start time and then each time a further half period (period nanoseconds divided by 2, rounded down) has been reached.
- R5: Every write to a channel clears both mode enables and drives its output to 0 on the following edge, before applying the new mode. A write with `cfg_on`=0 leaves the channel idle with a held 0 output.
- R6: An enabled channel drives pin `cfg_pin` (0..3) and sets that pin's `pin_oe`. A pin with no channel drives 0. If both channels select one pin, channel 0 supplies the value.
- R7: Enabling a channel on pin p clears any capture selection on p. Enabling a capture (`cap_idx` 0 or 1) on pin p removes any channel routed to p. If both writes name the same pin in one cycle, the output keeps the pin.
- R8: `irq_stat[0]` (channel 0) and `irq_stat[1]` (channel 1) are set by target-time hits only, never in frequency mode. They stay set until cleared through `irq_clr`. A set and a clear in the same cycle leave the bit set.
- R9: `irq_stat[2]` is set on every cycle where `tod_sec` differs from its value in the previous cycle.
- R10: `irq` is high exactly when some status bit is set and its bit in `irq_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tod_sec | input | 32 | Time of day, seconds |
| tod_ns | input | 32 | Time of day, nanoseconds (below 10^9) |
| cfg_wr | input | 1 | Channel programming strobe |
| cfg_ch | input | 1 | Channel index for the write |
| cfg_on | input | 1 | 1 enables the channel, 0 disables it |
| cfg_pin | input | 2 | Pin the channel drives |
| cfg_start_sec | input | 32 | Start time, seconds |
| cfg_start_ns | input | 32 | Start time, nanoseconds |
| cfg_per_sec | input | 32 | Period, seconds |
| cfg_per_ns | input | 32 | Period, nanoseconds |
| cap_wr | input | 1 | Capture selection strobe |
| cap_idx | input | 1 | Capture unit index |
| cap_on | input | 1 | Enables the capture on `cap_pin` |
| cap_pin | input | 2 | Pin the capture listens on |
| irq_mask | input | 3 | Per-status interrupt enables |
| irq_clr | input | 3 | Per-status clear pulses |
| pin_out | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables |
| cap_en | output | 2 | Capture enables after conflict removal |
| irq_stat | output | 3 | Sticky status: hit ch0, hit ch1, seconds change |
| irq | output | 1 | Masked interrupt request |

## Verification
Two clashes can land on one clock edge. The first is a channel's target hit together with a status clear for that channel. The bench freezes time, programs a target equal to the current time, and pulses the clear exactly one edge after the write, which is the edge of the hit. The status bit must stay set.

The second is a channel enable and a capture enable on the same pin in one cycle. Both strobes are issued together, and the router must end with the output driving the pin and the capture dropped. A cycle-accurate model in the bench checks both cases on every cycle, along with long sweeps across the period boundaries that decide the mode.

// File: rtl/tpo_pkg.sv
`timescale 1ns/1ps
package tpo_pkg;
  localparam int unsigned TW = 32;
  localparam logic [TW-1:0] NS_PER_SEC = 32'd1_000_000_000;

  typedef struct packed {
    logic [TW-1:0] sec;
    logic [TW-1:0] ns;
  } tstamp_t;

  // Sum of two time values; nanoseconds carry into seconds at one second.
  function automatic tstamp_t ts_add(tstamp_t a, tstamp_t b);
    logic [TW:0] nsum;
    tstamp_t     r;
    nsum  = {1'b0, a.ns} + {1'b0, b.ns};
    r.sec = a.sec + b.sec;
    if (nsum >= {1'b0, NS_PER_SEC}) begin
      nsum  = nsum - {1'b0, NS_PER_SEC};
      r.sec = r.sec + 1'b1;
    end
    r.ns = nsum[TW-1:0];
    return r;
  endfunction
endpackage

// File: rtl/tpo_chan.sv
`timescale 1ns/1ps
module tpo_chan
  import tpo_pkg::*;
#(
  parameter logic [TW-1:0] FREQ_MAX_NS = 32'd70_000_000,
  parameter logic [TW-1:0] FIX0_NS     = 32'd125_000_000,
  parameter logic [TW-1:0] FIX1_NS     = 32'd250_000_000,
  parameter logic [TW-1:0] FIX2_NS     = 32'd500_000_000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  tstamp_t tod,
  input  logic    wr,
  input  logic    on,
  input  tstamp_t start,
  input  tstamp_t per,
  output logic    out,
  output logic    hit_tt
);
  logic    tt_en_q, tt_en_d;
  logic    ck_en_q, ck_en_d;
  logic    ck_run_q, ck_run_d;
  logic    out_q, out_d;
  tstamp_t tgt_q, tgt_d;
  tstamp_t step_q, step_d;
  tstamp_t half_per;
  logic    pick_freq, active, reached, fire, ld;

  // R2: mode follows the requested period
  assign pick_freq = (per.sec == '0) &&
                     ((per.ns <= FREQ_MAX_NS) || (per.ns == FIX0_NS) ||
                      (per.ns == FIX1_NS) || (per.ns == FIX2_NS));
  assign half_per  = {{TW{1'b0}}, 1'b0, per.ns[TW-1:1]};

  assign active  = tt_en_q | (ck_en_q & ck_run_q);
  assign reached = ({tod.sec, tod.ns} >= {tgt_q.sec, tgt_q.ns});
  assign fire    = active & reached;
  assign ld      = wr | fire;

  always_comb begin
    tt_en_d  = tt_en_q;
    ck_en_d  = ck_en_q;
    ck_run_d = ck_run_q;
    out_d    = out_q;
    tgt_d    = tgt_q;
    step_d   = step_q;
    if (wr) begin
      // all three enables drop before the new mode is applied
      tt_en_d  = 1'b0;
      ck_en_d  = 1'b0;
      ck_run_d = 1'b0;
      if (on) begin
        tt_en_d  = ~pick_freq;
        ck_en_d  = pick_freq;
        ck_run_d = pick_freq;
      end
      tgt_d  = start;
      step_d = pick_freq ? half_per : per;
      out_d  = 1'b0;
    end else if (fire) begin
      out_d = ~out_q;
      tgt_d = ts_add(tgt_q, step_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tt_en_q  <= 1'b0;
      ck_en_q  <= 1'b0;
      ck_run_q <= 1'b0;
      out_q    <= 1'b0;
      tgt_q    <= '0;
      step_q   <= '0;
    end else if (ld) begin
      tt_en_q  <= tt_en_d;
      ck_en_q  <= ck_en_d;
      ck_run_q <= ck_run_d;
      out_q    <= out_d;
      tgt_q    <= tgt_d;
      step_q   <= step_d;
    end
  end

  assign out    = out_q;
  assign hit_tt = fire & tt_en_q;

  a_r5_wr_zeroes_out: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !out_q);
  a_r3_fire_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr) |=> (out_q != $past(out_q)));
  a_r2_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !(tt_en_q && ck_en_q));
endmodule

// File: rtl/tpo_route.sv
`timescale 1ns/1ps
module tpo_route #(
  parameter int NCH  = 2,
  parameter int NPIN = 4,
  parameter int NCAP = 2,
  localparam int PW    = (NPIN > 1) ? $clog2(NPIN) : 1,
  localparam int CH_W  = (NCH  > 1) ? $clog2(NCH)  : 1,
  localparam int CAP_W = (NCAP > 1) ? $clog2(NCAP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ch_out,
  input  logic             ch_wr,
  input  logic [CH_W-1:0]  ch_idx,
  input  logic             ch_on,
  input  logic [PW-1:0]    ch_pin,
  input  logic             cap_wr,
  input  logic [CAP_W-1:0] cap_idx,
  input  logic             cap_on,
  input  logic [PW-1:0]    cap_pin,
  output logic [NPIN-1:0]  pin_out,
  output logic [NPIN-1:0]  pin_oe,
  output logic [NCAP-1:0]  cap_en
);
  logic [NCH-1:0]  ren_q, ren_d;
  logic [PW-1:0]   rpin_q [NCH];
  logic [PW-1:0]   rpin_d [NCH];
  logic [NCAP-1:0] cen_q, cen_d;
  logic [PW-1:0]   cpin_q [NCAP];
  logic [PW-1:0]   cpin_d [NCAP];
  logic [NPIN-1:0] cap_on_pin;
  logic            upd;

  assign upd = ch_wr | cap_wr;

  always_comb begin
    ren_d  = ren_q;
    rpin_d = rpin_q;
    cen_d  = cen_q;
    cpin_d = cpin_q;
    for (int c = 0; c < NCH; c++) begin
      if (ch_wr && ch_idx == CH_W'(c)) begin
        ren_d[c]  = ch_on;
        rpin_d[c] = ch_pin;
      end
    end
    for (int k = 0; k < NCAP; k++) begin
      if (cap_wr && cap_idx == CAP_W'(k)) begin
        cen_d[k]  = cap_on;
        cpin_d[k] = cap_pin;
      end
    end
    // R7: a new output takes its pin away from any capture
    for (int k = 0; k < NCAP; k++) begin
      if (ch_wr && ch_on && cen_d[k] && cpin_d[k] == ch_pin)
        cen_d[k] = 1'b0;
    end
    // R7: a new capture removes outputs, unless an output claims it now
    for (int c = 0; c < NCH; c++) begin
      if (cap_wr && cap_on && ren_d[c] && rpin_d[c] == cap_pin &&
          !(ch_wr && ch_on && ch_pin == cap_pin))
        ren_d[c] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ren_q <= '0;
      cen_q <= '0;
      for (int c = 0; c < NCH; c++)  rpin_q[c] <= '0;
      for (int k = 0; k < NCAP; k++) cpin_q[k] <= '0;
    end else if (upd) begin
      ren_q  <= ren_d;
      cen_q  <= cen_d;
      rpin_q <= rpin_d;
      cpin_q <= cpin_d;
    end
  end

  // R6: lowest channel index wins a shared pin
  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      pin_oe[p]     = 1'b0;
      pin_out[p]    = 1'b0;
      cap_on_pin[p] = 1'b0;
      for (int c = NCH - 1; c >= 0; c--) begin
        if (ren_q[c] && rpin_q[c] == PW'(p)) begin
          pin_oe[p]  = 1'b1;
          pin_out[p] = ch_out[c];
        end
      end
      for (int k = 0; k < NCAP; k++) begin
        if (cen_q[k] && cpin_q[k] == PW'(p))
          cap_on_pin[p] = 1'b1;
      end
    end
  end

  assign cap_en = cen_q;

  for (genvar gp = 0; gp < NPIN; gp++) begin : g_pin_chk
    a_r7_pin_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pin_oe[gp] && cap_on_pin[gp]));
  end
endmodule

// File: rtl/tpo_irq.sv
`timescale 1ns/1ps
module tpo_irq
  import tpo_pkg::*;
#(
  parameter int NCH = 2,
  localparam int NS = NCH + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] hit,
  input  logic [TW-1:0] tod_sec,
  input  logic [NS-1:0] clr,
  input  logic [NS-1:0] mask,
  output logic [NS-1:0] stat,
  output logic          irq
);
  logic [TW-1:0] prev_sec_q;
  logic [NS-1:0] stat_q, stat_d, set;
  logic          wrap, ld;

  assign wrap   = (tod_sec != prev_sec_q);
  assign set    = {wrap, hit};
  assign ld     = (|set) | (|clr);
  assign stat_d = (stat_q & ~clr) | set;  // set wins over clear

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_sec_q <= '0;
    else        prev_sec_q <= tod_sec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stat_q <= '0;
    else if (ld) stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & mask);

  a_r9_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_sec != prev_sec_q) |=> stat_q[NS-1]);

  for (genvar gi = 0; gi < NS; gi++) begin : g_stat_chk
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[gi] && !clr[gi]) |=> stat_q[gi]);
  end
endmodule

// File: rtl/tgt_pulse_gen.sv
`timescale 1ns/1ps
module tgt_pulse_gen
  import tpo_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NPIN = 4,
  parameter int NCAP = 2,
  parameter logic [31:0] FREQ_MAX_NS = 32'd70_000_000,
  localparam int PW    = (NPIN > 1) ? $clog2(NPIN) : 1,
  localparam int CH_W  = (NCH  > 1) ? $clog2(NCH)  : 1,
  localparam int CAP_W = (NCAP > 1) ? $clog2(NCAP) : 1,
  localparam int NS    = NCH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      tod_sec,
  input  logic [31:0]      tod_ns,
  input  logic             cfg_wr,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic             cfg_on,
  input  logic [PW-1:0]    cfg_pin,
  input  logic [31:0]      cfg_start_sec,
  input  logic [31:0]      cfg_start_ns,
  input  logic [31:0]      cfg_per_sec,
  input  logic [31:0]      cfg_per_ns,
  input  logic             cap_wr,
  input  logic [CAP_W-1:0] cap_idx,
  input  logic             cap_on,
  input  logic [PW-1:0]    cap_pin,
  input  logic [NS-1:0]    irq_mask,
  input  logic [NS-1:0]    irq_clr,
  output logic [NPIN-1:0]  pin_out,
  output logic [NPIN-1:0]  pin_oe,
  output logic [NCAP-1:0]  cap_en,
  output logic [NS-1:0]    irq_stat,
  output logic             irq
);
  logic     rst_m_q, rst_sync_n;
  tstamp_t  tod_ts, start_ts, per_ts;
  logic [NCH-1:0] ch_out, ch_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_sync_n <= rst_m_q;
    end
  end

  assign tod_ts   = {tod_sec, tod_ns};
  assign start_ts = {cfg_start_sec, cfg_start_ns};
  assign per_ts   = {cfg_per_sec, cfg_per_ns};

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    tpo_chan #(
      .FREQ_MAX_NS (FREQ_MAX_NS)
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tod    (tod_ts),
      .wr     (cfg_wr && (cfg_ch == CH_W'(gi))),
      .on     (cfg_on),
      .start  (start_ts),
      .per    (per_ts),
      .out    (ch_out[gi]),
      .hit_tt (ch_hit[gi])
    );
  end

  tpo_route #(
    .NCH  (NCH),
    .NPIN (NPIN),
    .NCAP (NCAP)
  ) u_route (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ch_out  (ch_out),
    .ch_wr   (cfg_wr),
    .ch_idx  (cfg_ch),
    .ch_on   (cfg_on),
    .ch_pin  (cfg_pin),
    .cap_wr  (cap_wr),
    .cap_idx (cap_idx),
    .cap_on  (cap_on),
    .cap_pin (cap_pin),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .cap_en  (cap_en)
  );

  tpo_irq #(
    .NCH (NCH)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hit     (ch_hit),
    .tod_sec (tod_sec),
    .clr     (irq_clr),
    .mask    (irq_mask),
    .stat    (irq_stat),
    .irq     (irq)
  );
endmodule

// File: tb/tgt_pulse_gen_tb.sv
`timescale 1ns/1ps
module tgt_pulse_gen_tb;
  localparam logic [31:0] SEC_NS = 32'd1_000_000_000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tod_sec, tod_ns;
  logic        cfg_wr, cfg_ch, cfg_on;
  logic [1:0]  cfg_pin;
  logic [31:0] cfg_start_sec, cfg_start_ns, cfg_per_sec, cfg_per_ns;
  logic        cap_wr, cap_idx, cap_on;
  logic [1:0]  cap_pin;
  logic [2:0]  irq_mask, irq_clr;
  logic [3:0]  pin_out, pin_oe;
  logic [1:0]  cap_en;
  logic [2:0]  irq_stat;
  logic        irq;

  always #2.5 clk = ~clk;  // 200 MHz

  tgt_pulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_on(cfg_on), .cfg_pin(cfg_pin),
    .cfg_start_sec(cfg_start_sec), .cfg_start_ns(cfg_start_ns),
    .cfg_per_sec(cfg_per_sec), .cfg_per_ns(cfg_per_ns),
    .cap_wr(cap_wr), .cap_idx(cap_idx), .cap_on(cap_on), .cap_pin(cap_pin),
    .irq_mask(irq_mask), .irq_clr(irq_clr),
    .pin_out(pin_out), .pin_oe(pin_oe), .cap_en(cap_en),
    .irq_stat(irq_stat), .irq(irq)
  );

  // requirement model state
  logic        m_tt [2], m_ck [2], m_out [2], m_ren [2], m_cen [2];
  logic [31:0] m_ts [2], m_tn [2], m_ss [2], m_sn [2];
  logic [1:0]  m_rp [2], m_cp [2];
  logic [2:0]  m_stat;
  logic [31:0] m_prev;
  logic [31:0] tstep;
  int          vecs = 0;
  int          miss = 0;
  bit          done = 1'b0;
  string       cur_req = "R1";

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s act=%h exp=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic bit is_freq(logic [31:0] ps, logic [31:0] pn);
    return (ps == 0) && (pn <= 32'd70_000_000 || pn == 32'd125_000_000 ||
                         pn == 32'd250_000_000 || pn == 32'd500_000_000);
  endfunction

  task automatic model_step();
    logic       fire [2];
    logic [1:0] hit;
    logic       wrap, fq;
    logic [32:0] ns;
    for (int c = 0; c < 2; c++) begin
      fire[c] = (m_tt[c] | m_ck[c]) && ({tod_sec, tod_ns} >= {m_ts[c], m_tn[c]});
      hit[c]  = fire[c] & m_tt[c];
    end
    wrap   = (tod_sec != m_prev);
    m_prev = tod_sec;
    m_stat = (m_stat & ~irq_clr) | {wrap, hit};
    for (int c = 0; c < 2; c++) begin
      if (cfg_wr && cfg_ch == 1'(c)) begin
        fq      = is_freq(cfg_per_sec, cfg_per_ns);
        m_tt[c] = cfg_on & ~fq;
        m_ck[c] = cfg_on & fq;
        m_ts[c] = cfg_start_sec;
        m_tn[c] = cfg_start_ns;
        m_ss[c] = fq ? 32'd0 : cfg_per_sec;
        m_sn[c] = fq ? (cfg_per_ns >> 1) : cfg_per_ns;
        m_out[c] = 1'b0;
      end else if (fire[c]) begin
        m_out[c] = ~m_out[c];
        ns = {1'b0, m_tn[c]} + {1'b0, m_sn[c]};
        m_ts[c] = m_ts[c] + m_ss[c];
        if (ns >= {1'b0, SEC_NS}) begin
          ns = ns - {1'b0, SEC_NS};
          m_ts[c] = m_ts[c] + 1;
        end
        m_tn[c] = ns[31:0];
      end
    end
    if (cfg_wr) begin
      m_ren[cfg_ch] = cfg_on;
      m_rp[cfg_ch]  = cfg_pin;
    end
    if (cap_wr) begin
      m_cen[cap_idx] = cap_on;
      m_cp[cap_idx]  = cap_pin;
    end
    for (int k = 0; k < 2; k++)
      if (cfg_wr && cfg_on && m_cen[k] && m_cp[k] == cfg_pin) m_cen[k] = 1'b0;
    for (int c = 0; c < 2; c++)
      if (cap_wr && cap_on && m_ren[c] && m_rp[c] == cap_pin &&
          !(cfg_wr && cfg_on && cfg_pin == cap_pin)) m_ren[c] = 1'b0;
  endtask

  task automatic check_all();
    logic [3:0] eoe, eout;
    eoe = '0; eout = '0;
    for (int p = 0; p < 4; p++)
      for (int c = 1; c >= 0; c--)
        if (m_ren[c] && m_rp[c] == 2'(p)) begin
          eoe[p]  = 1'b1;
          eout[p] = m_out[c];
        end
    vecs++;
    chk("pin_oe",   {4'b0, pin_oe},   {4'b0, eoe});
    chk("pin_out",  {4'b0, pin_out},  {4'b0, eout});
    chk("cap_en",   {6'b0, cap_en},   {6'b0, m_cen[1], m_cen[0]});
    chk("irq_stat", {5'b0, irq_stat}, {5'b0, m_stat});
    chk("irq",      {7'b0, irq},      {7'b0, |(m_stat & irq_mask)});
  endtask

  task automatic tick();
    logic [32:0] ns;
    @(negedge clk);
    model_step();
    check_all();
    cfg_wr = 1'b0; cap_wr = 1'b0; irq_clr = '0;
    ns = {1'b0, tod_ns} + {1'b0, tstep};
    if (ns >= {1'b0, SEC_NS}) begin
      ns = ns - {1'b0, SEC_NS};
      tod_sec = tod_sec + 1;
    end
    tod_ns = ns[31:0];
  endtask

  task automatic prog(int ch, bit on, int pin, logic [31:0] off, logic [63:0] per);
    logic [32:0] ns;
    cfg_wr = 1'b1; cfg_ch = ch[0]; cfg_on = on; cfg_pin = pin[1:0];
    ns = {1'b0, tod_ns} + {1'b0, off};
    cfg_start_sec = tod_sec;
    if (ns >= {1'b0, SEC_NS}) begin
      ns = ns - {1'b0, SEC_NS};
      cfg_start_sec = tod_sec + 1;
    end
    cfg_start_ns = ns[31:0];
    cfg_per_sec = per[63:32];
    cfg_per_ns  = per[31:0];
  endtask

  task automatic cap_set(int idx, bit on, int pin);
    cap_wr = 1'b1; cap_idx = idx[0]; cap_on = on; cap_pin = pin[1:0];
  endtask

  // period sweep across the mode boundaries (R2)
  function automatic logic [63:0] per_tab(int i);
    case (i)
      0: return {32'd0, 32'd69_999_999};
      1: return {32'd0, 32'd70_000_000};
      2: return {32'd0, 32'd70_000_001};
      3: return {32'd0, 32'd124_999_999};
      4: return {32'd0, 32'd125_000_000};
      5: return {32'd0, 32'd250_000_000};
      6: return {32'd0, 32'd500_000_000};
      default: return {32'd1, 32'd300_000_000};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL %s watchdog act=running exp=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    logic [63:0] pv;
    rst_n = 1'b0; tod_sec = '0; tod_ns = '0; tstep = '0;
    cfg_wr = 0; cfg_ch = 0; cfg_on = 0; cfg_pin = 0;
    cfg_start_sec = 0; cfg_start_ns = 0; cfg_per_sec = 0; cfg_per_ns = 0;
    cap_wr = 0; cap_idx = 0; cap_on = 0; cap_pin = 0;
    irq_mask = '0; irq_clr = '0;
    for (int c = 0; c < 2; c++) begin
      m_tt[c] = 0; m_ck[c] = 0; m_out[c] = 0; m_ren[c] = 0; m_cen[c] = 0;
      m_ts[c] = 0; m_tn[c] = 0; m_ss[c] = 0; m_sn[c] = 0; m_rp[c] = 0; m_cp[c] = 0;
    end
    m_stat = '0; m_prev = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check_all();
    rst_n = 1'b1;
    repeat (4) tick();

    // R2 sweep with R3 / R4 behaviour on both channels
    tstep = 32'd7_000_000;
    irq_mask = 3'b011;
    for (int pi = 0; pi < 8; pi++) begin
      pv = per_tab(pi);
      cur_req = is_freq(pv[63:32], pv[31:0]) ? "R2/R4" : "R2/R3";
      prog(0, 1, 0, 32'd20_000_000, pv);
      tick();
      prog(1, 1, 1, 32'd13_000_000, per_tab(7 - pi));
      tick();
      repeat (150) tick();
    end

    // R5: reprogram and disable
    cur_req = "R5";
    tstep = 32'd1_000_000;
    prog(0, 1, 0, 32'd2_000_000, {32'd0, 32'd10_000_000});
    tick();
    repeat (20) tick();
    prog(0, 0, 0, 32'd0, {32'd0, 32'd10_000_000});
    tick();
    repeat (20) tick();
    prog(0, 1, 0, 32'd0, {32'd0, 32'd90_000_000});
    tick();
    repeat (30) tick();
    prog(0, 1, 0, 32'd0, {32'd0, 32'd20_000_000});
    tick();
    repeat (10) tick();

    // R6: shared pin, channel 0 wins
    cur_req = "R6";
    prog(0, 1, 1, 32'd0, {32'd0, 32'd4_000_000});
    tick();
    prog(1, 1, 1, 32'd0, {32'd0, 32'd6_000_000});
    tick();
    repeat (30) tick();

    // R7: input / output exclusivity
    cur_req = "R7";
    cap_set(0, 1, 2);
    tick();
    prog(1, 1, 2, 32'd0, {32'd0, 32'd6_000_000});
    tick();
    repeat (5) tick();
    cap_set(1, 1, 1);
    tick();
    repeat (5) tick();
    prog(0, 1, 3, 32'd0, {32'd0, 32'd4_000_000});
    cap_set(0, 1, 3);
    tick();
    repeat (5) tick();

    // R8: hit and clear on one edge, set wins
    cur_req = "R8";
    tstep = '0;
    prog(0, 0, 0, 32'd0, {32'd0, 32'd4_000_000});
    tick();
    prog(1, 0, 1, 32'd0, {32'd0, 32'd4_000_000});
    tick();
    irq_clr = 3'b111;
    tick();
    irq_mask = 3'b001;
    prog(0, 1, 0, 32'd0, {32'd10, 32'd0});
    tick();
    irq_clr = 3'b001;
    tick();
    repeat (3) tick();

    // R10: mask gating
    cur_req = "R10";
    irq_mask = 3'b010;
    tick();
    tick();
    irq_mask = 3'b001;
    irq_clr = 3'b001;
    tick();
    tick();

    // R8: frequency mode never flags
    cur_req = "R8";
    irq_mask = 3'b011;
    tstep = 32'd1_000_000;
    prog(1, 1, 1, 32'd0, {32'd0, 32'd4_000_000});
    tick();
    repeat (20) tick();

    // R9: seconds change status
    cur_req = "R9";
    tstep = 32'd250_000_000;
    irq_mask = 3'b100;
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 0) irq_clr = 3'b100;
      tick();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule